// File: doc/BRIEF.md
# UART Receive Queue with DMA Requests and Idle Timeout

This block holds received UART characters between the serial deserializer and the system bus. Each accepted character is stored with its line-error status in a 32-entry queue and returned in arrival order through a read port. Two DMA request outputs announce data to a DMA engine:
- a single-character request, raised while any entry is queued;
- a burst request, raised once the fill passes a programmable trip point.

A level interrupt, an idle-timeout interrupt and a combined error interrupt are produced. Each is the raw status gated by an enable mask.

The timeout watches for a quiet line while data is still waiting. Once a received character or a read is seen, it needs 32 bit-period ticks with neither before it fires, and it only counts while the queue holds data. A DMA engine served from the single-character request empties the queue as fast as characters arrive. In that case the timeout can never fire, so the two request outputs are not interchangeable, and a system must pick one with this in mind. Error flags and the overrun flag stay set until software clears them with a write-one-to-clear strobe.

Top module: `uart_rx_fifo_dma`

## Requirements
- R1: Each entry is 12 bits wide, with the character in bits 7:0 and error status in bits 11:8. Entries are read back in arrival order, and `rd_data` shows the oldest entry.
- R2: `dma_sreq` is high whenever the queue holds one or more entries and `dma_done` is low.
- R3: `dma_breq` is high only while the entry count is strictly greater than the trip point. Watermark code 0 selects 4, code 1 selects 8, code 2 selects 16, code 3 selects 24, and codes 4 to 7 select 28. The burst request also needs `dma_done` low.
- R4: The raw level status is the entry count being at least the trip point. Each interrupt output is its raw status ANDed with its mask bit. The mask bits are: bit 0 level, bit 1 timeout, bit 2 framing, bit 3 parity, bit 4 break, bit 5 overrun. `irq_err` is the OR of masked bits 2 to 5.
- R5: While the queue is non-empty, the timeout status sets on the 32nd `bit_tick` after the last received character or the last read. Either event restarts the count, and no ticks are counted while the queue is empty.
- R6: The timeout status clears when a read leaves the queue empty, or when `clr_bits` bit 1 is written with `clr_we`. No other read clears it.
- R7: An accepted character with bit 8 set latches framing (status bit 2). Bit 9 latches parity (status bit 3) and bit 10 latches break (status bit 4). Each stays set until cleared through the matching `clr_bits` bit.
- R8: A character arriving while the queue is full and not being read is dropped. Queue contents are left unchanged and overrun (status bit 5) is set, staying set until cleared through `clr_bits` bit 5.
- R9: While `dma_done` is high, both DMA requests are low. They re-evaluate from the queue fill as soon as it falls.
- R10: A read while the queue is empty is ignored: `rd_data` reads 0 and no entry is lost or created.
- R11: After reset the queue is empty and all DMA request and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Received-character strobe from the deserializer |
| in_word | input | 12 | Character (7:0) with error bits (11:8) |
| bit_tick | input | 1 | One pulse per serial bit period |
| rd_en | input | 1 | Bus read of the oldest entry |
| rd_data | output | 12 | Oldest entry, 0 when empty |
| cfg_wmark | input | 3 | Watermark trip-point code |
| irq_mask | input | 6 | Interrupt enable mask |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_bits | input | 6 | Write-one-to-clear status bits |
| dma_done | input | 1 | DMA transfer-complete pulse |
| dma_sreq | output | 1 | Single-character DMA request |
| dma_breq | output | 1 | Burst DMA request |
| irq_rx | output | 1 | Masked level interrupt |
| irq_rt | output | 1 | Masked receive-timeout interrupt |
| irq_err | output | 1 | Masked OR of error and overrun status |

## Verification
The queue is filled one character at a time up to 29 entries, and every watermark code is tried at every fill. This separates the strict greater-than compare of the burst request from the at-least compare of the level status, at exactly the count where they differ. The idle timer is tried with 31 against 32 ticks, with a read in the middle that must restart it, and with a DMA model that drains on the single request so the queue never stays occupied. That last pattern tells a timer gated on queue content apart from one that merely counts quiet time. An overfill followed by a full drain shows that the dropped character never enters the stream, and error-tagged characters show each flag latching separately and surviving the read of its own character.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   // Interrupt status / mask / clear bit positions.
   localparam int IRQ_W   = 6;
   localparam int IRQ_LVL = 0;
   localparam int IRQ_TMO = 1;
   localparam int IRQ_FRM = 2;
   localparam int IRQ_PAR = 3;
   localparam int IRQ_BRK = 4;
   localparam int IRQ_OVR = 5;

   // Offsets of line errors inside the error field of an entry.
   localparam int ERR_FRM_OFS = 0;
   localparam int ERR_PAR_OFS = 1;
   localparam int ERR_BRK_OFS = 2;

   // Number of distinct watermark trip points.
   localparam int NUM_TRIPS = 5;

   typedef logic [IRQ_W-1:0] irq_vec_t;

   // Trip point in eighths of the depth for each watermark code.
   function automatic int trip_eighths(input int idx);
      case (idx)
         0:       return 1;
         1:       return 2;
         2:       return 4;
         3:       return 6;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
   parameter int ENTRY_W = 12,
   parameter int DEPTH   = 32,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_req,
   input  logic [ENTRY_W-1:0] wr_word,
   input  logic               rd_req,
   output logic [ENTRY_W-1:0] rd_word,
   output logic [CNT_W-1:0]   count,
   output logic               empty,
   output logic               full,
   output logic               wr_fire,
   output logic               rd_fire,
   output logic               drop,
   output logic               drain
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [PTR_W-1:0]   wr_ptr_nx, rd_ptr_nx;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign rd_fire = rd_req && !empty;
   assign wr_fire = wr_req && (!full || rd_fire);
   assign drop    = wr_req && !wr_fire;
   assign drain   = rd_fire && !wr_fire && (count == CNT_W'(1));
   assign rd_word = empty ? '0 : mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_ptr_nx = wr_ptr + 1'b1;
         assign rd_ptr_nx = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_fire) begin
         mem[wr_ptr] <= wr_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_fire) begin
            wr_ptr <= wr_ptr_nx;
         end
         if (rd_fire) begin
            rd_ptr <= rd_ptr_nx;
         end
         case ({wr_fire, rd_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R8

   AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (full && $stable(wr_ptr))); // R8

   AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty && !wr_req) |=> (empty && $stable(rd_ptr))); // R10

endmodule

// File: rtl/rxq_trip.sv
module rxq_trip
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int CODE_W = 3,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0]  count,
   input  logic [CODE_W-1:0] code,
   input  logic              dma_done,
   output logic              sreq,
   output logic              breq,
   output logic              lvl_hit
);

   logic [CNT_W-1:0]  trip_tab [NUM_TRIPS];
   logic [CODE_W-1:0] idx;
   logic [CNT_W-1:0]  thr;

   generate
      for (genvar g = 0; g < NUM_TRIPS; g++) begin : g_trip
         localparam int TRIP = (DEPTH * trip_eighths(g)) / 8;
         assign trip_tab[g] = CNT_W'(TRIP);
      end
   endgenerate

   // Codes beyond the table clamp to the highest trip point.
   assign idx     = (code >= CODE_W'(NUM_TRIPS - 1)) ? CODE_W'(NUM_TRIPS - 1) : code;
   assign thr     = trip_tab[idx];
   assign lvl_hit = (count >= thr);
   assign sreq    = (count != '0) && !dma_done;
   assign breq    = (count > thr) && !dma_done;

endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
   parameter int IDLE_TICKS = 32,
   localparam int IW        = $clog2(IDLE_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic hold_empty,
   output logic fire
);

   logic [IW-1:0] idle;

   assign fire = tick && !restart && !hold_empty && (idle == IW'(IDLE_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle <= '0;
      end else if (restart || hold_empty) begin
         idle <= '0;
      end else if (tick && (idle < IW'(IDLE_TICKS))) begin
         idle <= idle + 1'b1;
      end
   end

   AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (idle == '0)); // R5

   AST_IDLE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      idle <= IW'(IDLE_TICKS)); // R5

   AST_NO_COUNT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      hold_empty |=> (idle == '0)); // R5

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
   import uart_rxq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  irq_vec_t set_vec,
   input  logic     lvl_raw,
   input  logic     tmo_auto_clr,
   input  logic     clr_we,
   input  irq_vec_t clr_bits,
   input  irq_vec_t mask,
   output logic     irq_rx,
   output logic     irq_rt,
   output logic     irq_err
);

   irq_vec_t sticky;
   irq_vec_t raw;
   logic     unused_lvl_clr;
   logic     unused_lvl_set;

   // The level status is not latched; its clear and set bits do nothing.
   assign unused_lvl_clr = clr_bits[IRQ_LVL];
   assign unused_lvl_set = set_vec[IRQ_LVL];
   assign sticky[IRQ_LVL] = 1'b0;

   generate
      for (genvar i = 1; i < IRQ_W; i++) begin : g_sticky
         localparam bit AUTO = (i == IRQ_TMO);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sticky[i] <= 1'b0;
            end else begin
               sticky[i] <= set_vec[i] ||
                            (sticky[i] && !(clr_we && clr_bits[i]) && !(AUTO && tmo_auto_clr));
            end
         end
      end
   endgenerate

   assign raw     = {sticky[IRQ_W-1:1], lvl_raw};
   assign irq_rx  = raw[IRQ_LVL] && mask[IRQ_LVL];
   assign irq_rt  = raw[IRQ_TMO] && mask[IRQ_TMO];
   assign irq_err = |(raw[IRQ_OVR:IRQ_FRM] & mask[IRQ_OVR:IRQ_FRM]);

   AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky[IRQ_FRM] && !(clr_we && clr_bits[IRQ_FRM])) |=> sticky[IRQ_FRM]); // R7

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky[IRQ_OVR] && !(clr_we && clr_bits[IRQ_OVR])) |=> sticky[IRQ_OVR]); // R8

   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[IRQ_PAR] && !set_vec[IRQ_PAR]) |=> !sticky[IRQ_PAR]); // R7

endmodule

// File: rtl/uart_rx_fifo_dma.sv
module uart_rx_fifo_dma
   import uart_rxq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ERR_W      = 4,
   parameter int DEPTH      = 32,
   parameter int IDLE_TICKS = 32,
   parameter int CODE_W     = 3,
   localparam int ENTRY_W   = DATA_W + ERR_W,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic [ENTRY_W-1:0] in_word,
   input  logic               bit_tick,
   input  logic               rd_en,
   output logic [ENTRY_W-1:0] rd_data,
   input  logic [CODE_W-1:0]  cfg_wmark,
   input  logic [IRQ_W-1:0]   irq_mask,
   input  logic               clr_we,
   input  logic [IRQ_W-1:0]   clr_bits,
   input  logic               dma_done,
   output logic               dma_sreq,
   output logic               dma_breq,
   output logic               irq_rx,
   output logic               irq_rt,
   output logic               irq_err
);

   initial begin : elab_checks
      assert (DEPTH >= 8) else $error("DEPTH must be at least 8");
      assert (ERR_W >= 3) else $error("ERR_W must hold frame, parity and break");
      assert (IDLE_TICKS >= 2) else $error("IDLE_TICKS must be at least 2");
      assert (CODE_W >= 3) else $error("CODE_W must encode all trip points");
   end

   logic [CNT_W-1:0] count;
   logic             empty, full, wr_fire, rd_fire, drop, drain;
   logic             lvl_hit, tmo_fire;
   logic [ERR_W-1:0] err_in;
   irq_vec_t         set_vec;

   assign err_in = in_word[DATA_W +: ERR_W];

   rxq_ring #(
      .ENTRY_W (ENTRY_W),
      .DEPTH   (DEPTH)
   ) i_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (in_vld),
      .wr_word (in_word),
      .rd_req  (rd_en),
      .rd_word (rd_data),
      .count   (count),
      .empty   (empty),
      .full    (full),
      .wr_fire (wr_fire),
      .rd_fire (rd_fire),
      .drop    (drop),
      .drain   (drain)
   );

   rxq_trip #(
      .DEPTH  (DEPTH),
      .CODE_W (CODE_W)
   ) i_trip (
      .count    (count),
      .code     (cfg_wmark),
      .dma_done (dma_done),
      .sreq     (dma_sreq),
      .breq     (dma_breq),
      .lvl_hit  (lvl_hit)
   );

   rxq_idle #(
      .IDLE_TICKS (IDLE_TICKS)
   ) i_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (bit_tick),
      .restart    (in_vld || rd_fire),
      .hold_empty (empty),
      .fire       (tmo_fire)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[IRQ_TMO] = tmo_fire;
      set_vec[IRQ_FRM] = wr_fire && err_in[ERR_FRM_OFS];
      set_vec[IRQ_PAR] = wr_fire && err_in[ERR_PAR_OFS];
      set_vec[IRQ_BRK] = wr_fire && err_in[ERR_BRK_OFS];
      set_vec[IRQ_OVR] = drop;
   end

   rxq_flags i_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_vec      (set_vec),
      .lvl_raw      (lvl_hit),
      .tmo_auto_clr (empty || drain),
      .clr_we       (clr_we),
      .clr_bits     (clr_bits),
      .mask         (irq_mask),
      .irq_rx       (irq_rx),
      .irq_rt       (irq_rt),
      .irq_err      (irq_err)
   );

   AST_TMO_GONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      empty |=> !irq_rt); // R6

   AST_FULL_BURSTS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !dma_done) |-> dma_breq); // R3

   AST_DONE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done && !empty) |-> (!dma_sreq && !dma_breq)); // R9

   AST_SREQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !dma_done) |-> dma_sreq); // R2

endmodule

// File: tb/test_uart_rx_fifo_dma.sv
module test_uart_rx_fifo_dma;

   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [11:0] in_word = '0;
   logic        bit_tick = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_data;
   logic [2:0]  cfg_wmark = '0;
   logic [5:0]  irq_mask = '0;
   logic        clr_we = 1'b0;
   logic [5:0]  clr_bits = '0;
   logic        dma_done = 1'b0;
   logic        dma_sreq, dma_breq, irq_rx, irq_rt, irq_err;

   int checks = 0;
   int fails  = 0;
   logic [11:0] exp_q [$];

   always #4 clk = ~clk;

   uart_rx_fifo_dma i_uart_rx_fifo_dma (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (in_vld),
      .in_word   (in_word),
      .bit_tick  (bit_tick),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .cfg_wmark (cfg_wmark),
      .irq_mask  (irq_mask),
      .clr_we    (clr_we),
      .clr_bits  (clr_bits),
      .dma_done  (dma_done),
      .dma_sreq  (dma_sreq),
      .dma_breq  (dma_breq),
      .irq_rx    (irq_rx),
      .irq_rt    (irq_rt),
      .irq_err   (irq_err)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int trip(input int code);
      case (code)
         0: return 4;
         1: return 8;
         2: return 16;
         3: return 24;
         default: return 28;
      endcase
   endfunction

   // Scoreboard side: driver pushes, monitor pops on reads.
   always @(negedge clk) begin
      if (rst_n && in_vld && exp_q.size() < DEPTH) begin
         exp_q.push_back(in_word);
      end
      if (rst_n && rd_en) begin
         if (exp_q.size() > 0) begin
            chk("R1", int'(rd_data), int'(exp_q.pop_front()), "read order/content");
         end else begin
            chk("R10", int'(rd_data), 0, "read of empty queue");
         end
      end
   end

   task automatic settle;
      @(negedge clk);
   endtask

   task automatic put(input logic [11:0] w);
      @(posedge clk); #1;
      in_vld = 1'b1; in_word = w;
      @(posedge clk); #1;
      in_vld = 1'b0;
   endtask

   task automatic get;
      @(posedge clk); #1;
      rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         bit_tick = 1'b1;
         @(posedge clk); #1;
         bit_tick = 1'b0;
      end
   endtask

   task automatic clear(input logic [5:0] b);
      @(posedge clk); #1;
      clr_we = 1'b1; clr_bits = b;
      @(posedge clk); #1;
      clr_we = 1'b0; clr_bits = '0;
   endtask

   initial begin : watchdog
      #(200000 * 8);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      irq_mask = 6'h3f;
      settle;
      chk("R11", int'(dma_sreq), 0, "sreq after reset");
      chk("R11", int'(dma_breq), 0, "breq after reset");
      chk("R11", int'({irq_rx, irq_rt, irq_err}), 0, "interrupts after reset");
      chk("R11", int'(rd_data), 0, "rd_data after reset");

      // R10: read of empty queue is ignored
      get;
      settle;
      chk("R10", int'(dma_sreq), 0, "no entry after empty read");
      put(12'h055);
      settle;
      chk("R2", int'(dma_sreq), 1, "sreq with one entry");
      get;

      // R3/R4: fill and sweep every watermark code at every count
      for (int n = 1; n <= 29; n++) begin
         put(12'(n));
         for (int c = 0; c < 8; c++) begin
            cfg_wmark = 3'(c);
            settle;
            chk("R3", int'(dma_breq), int'(n > trip(c)), $sformatf("breq n=%0d code=%0d", n, c));
            chk("R4", int'(irq_rx), int'(n >= trip(c)), $sformatf("level n=%0d code=%0d", n, c));
            @(posedge clk); #1;
         end
      end
      chk("R2", int'(dma_sreq), 1, "sreq with 29 entries");
      irq_mask = 6'h3e;
      settle;
      chk("R4", int'(irq_rx), 0, "level masked off");
      irq_mask = 6'h3f;

      // R5/R6: idle timeout
      ticks(31);
      settle;
      chk("R5", int'(irq_rt), 0, "no timeout after 31 ticks");
      ticks(1);
      settle;
      chk("R5", int'(irq_rt), 1, "timeout after 32 ticks");
      irq_mask = 6'h3d;
      settle;
      chk("R4", int'(irq_rt), 0, "timeout masked off");
      irq_mask = 6'h3f;
      get;
      settle;
      chk("R6", int'(irq_rt), 1, "non-emptying read keeps timeout");
      clear(6'h02);
      settle;
      chk("R6", int'(irq_rt), 0, "clear bit 1 drops timeout");
      ticks(31);
      get;
      ticks(31);
      settle;
      chk("R5", int'(irq_rt), 0, "read restarted idle count");
      ticks(1);
      settle;
      chk("R5", int'(irq_rt), 1, "timeout 32 ticks after read");
      clear(6'h02);

      // R8: overrun; 27 entries now
      for (int k = 0; k < 5; k++) put(12'(8'h60 + k));
      irq_mask = 6'h20;
      settle;
      chk("R8", int'(irq_err), 0, "no overrun before overfill");
      put(12'h0ab);
      settle;
      chk("R8", int'(irq_err), 1, "overrun set by dropped char");

      // R9: done pulse silences both requests
      @(posedge clk); #1;
      dma_done = 1'b1;
      settle;
      chk("R9", int'(dma_sreq), 0, "sreq during done");
      chk("R9", int'(dma_breq), 0, "breq during done");
      @(posedge clk); #1;
      dma_done = 1'b0;
      settle;
      chk("R9", int'(dma_sreq), 1, "sreq after done");
      chk("R9", int'(dma_breq), 1, "breq after done");

      irq_mask = 6'h3f;
      ticks(32);
      settle;
      chk("R5", int'(irq_rt), 1, "timeout with full queue");
      for (int k = 0; k < DEPTH; k++) get;
      settle;
      chk("R6", int'(irq_rt), 0, "drain clears timeout");
      chk("R2", int'(dma_sreq), 0, "sreq low when drained");
      irq_mask = 6'h20;
      settle;
      chk("R8", int'(irq_err), 1, "overrun sticky after drain");
      clear(6'h20);
      settle;
      chk("R8", int'(irq_err), 0, "overrun cleared");

      // R7: error flags
      put(12'h141);
      irq_mask = 6'h04;
      settle;
      chk("R7", int'(irq_err), 1, "framing latched");
      irq_mask = 6'h08;
      settle;
      chk("R7", int'(irq_err), 0, "parity not set by framing");
      get;
      irq_mask = 6'h04;
      settle;
      chk("R7", int'(irq_err), 1, "framing sticky after read");
      clear(6'h04);
      settle;
      chk("R7", int'(irq_err), 0, "framing cleared");
      put(12'h242);
      irq_mask = 6'h08;
      settle;
      chk("R7", int'(irq_err), 1, "parity latched");
      clear(6'h08);
      settle;
      chk("R7", int'(irq_err), 0, "parity cleared");
      put(12'h443);
      irq_mask = 6'h10;
      settle;
      chk("R7", int'(irq_err), 1, "break latched");
      clear(6'h10);
      settle;
      chk("R7", int'(irq_err), 0, "break cleared");
      get;
      get;

      // R5: single-request DMA keeps queue empty, timeout never fires
      irq_mask = 6'h3f;
      put(12'h07e);
      while (dma_sreq) get;
      ticks(40);
      settle;
      chk("R5", int'(irq_rt), 0, "no timeout while DMA drains");
      chk("R2", int'(dma_sreq), 0, "sreq low after DMA drain");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule